// File: doc/BRIEF.md
# Double-Buffered Recirculating Filter Weight Feeder

This block feeds filter coefficients, one per cycle, into the top of a single column of a convolution systolic array. Coefficients arrive serially and are shifted into a standby register chain. Once that chain holds a complete filter of w² coefficients, a swap strobe copies it in one cycle into a working chain. The working chain then drives the column while the standby chain is refilled with the next filter. Loading and consuming therefore overlap, and no cycles are lost between filters.

The programmed mask size w sets the length of the working ring. The array has as many rows as the square of the smallest supported w. For larger masks, the weight that leaves toward the array is carried back through a return path as deep as the row count. It re-enters the working chain at position w² minus the row count, counted from the output end starting at 1. This lets the same filter be applied to one group of masks after another without being reloaded.

Top module: `pingpong_weight_buf`

## Requirements
- R1: After reset, weight_out is 0 and full is 0.
- R2: The effective mask size is w_sel clamped into the range W_MIN..W_MAX (3..5 by default). A value below the range acts as W_MIN and a value above it acts as W_MAX. The filter length N is the square of the effective size.
- R3: full rises after exactly N accepted load strobes. A load strobe while full is high, in a cycle where no swap is accepted, is ignored, and the stored filter keeps its first N values.
- R4: A swap strobe is accepted only when full is high and the working ring is consumed. The ring is consumed if no swap has been accepted since reset, or if at least N advance strobes have occurred since the last accepted swap. Any other swap strobe is ignored.
- R5: In the cycle after an accepted swap, weight_out shows the first coefficient loaded into the filter and full is 0.
- R6: Each advance strobe after a swap moves weight_out to the next coefficient in load order. After the N-th coefficient the sequence wraps back to the first, so the filter recirculates indefinitely.
- R7: Until the first accepted swap after reset, weight_out is 0 and advance strobes have no effect on it.
- R8: A load strobe in the same cycle as an accepted swap is kept as the first coefficient of the next filter.
- R9: An advance strobe in the same cycle as an accepted swap is ignored. The next cycle shows the first coefficient of the new filter.
- R10: Loading the standby chain while the working ring advances does not disturb the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| w_sel | input | WSW | Programmed mask size w, held stable for the whole life of a filter |
| load | input | 1 | Strobe: shift load_data into the standby chain |
| load_data | input | DW | Serial coefficient input |
| swap | input | 1 | Strobe: request copy of the standby chain into the working ring |
| advance | input | 1 | Strobe: present the next coefficient to the array |
| weight_out | output | DW | Coefficient toward the top processing element |
| full | output | 1 | Standby chain holds a complete filter |

## Verification
Three functions can fall in the same edge: the swap, the next filter's first load, and the column's advance. The swap can arrive in the very cycle the working ring becomes consumed, with a load and an advance asserted at the same time. A directed step drives all three strobes together just as the advance count reaches N, and random runs hit the same collision many more times. The result is judged on the following cycles. weight_out must be the new filter's first coefficient with no step taken, full must be low, and the coincident load must come out first once the next filter is swapped in.

// File: rtl/pingpong_weight_buf.sv
module pingpong_weight_buf #(
  parameter int DW    = 8,
  parameter int W_MIN = 3,
  parameter int W_MAX = 5,
  parameter int WSW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WSW-1:0] w_sel,
  input  logic           load,
  input  logic [DW-1:0]  load_data,
  input  logic           swap,
  input  logic           advance,
  output logic [DW-1:0]  weight_out,
  output logic           full
);
  localparam int ROWS  = W_MIN * W_MIN;
  localparam int DEPTH = W_MAX * W_MAX;
  localparam int ABUF  = DEPTH - ROWS;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [DW-1:0] pas [DEPTH];
  logic [DW-1:0] act [ABUF];
  logic [DW-1:0] ret [ROWS];
  logic [DW-1:0] pick [ABUF];
  logic [CW-1:0] pcnt, acnt, n, k;
  logic          primed, consumed, take, ld_ok;
  int            weff;

  always_comb begin
    weff = int'(w_sel);
    if (weff < W_MIN) weff = W_MIN;
    else if (weff > W_MAX) weff = W_MAX;
  end

  assign n        = CW'(weff * weff);
  assign k        = n - CW'(ROWS);
  assign full     = pcnt >= n;
  assign consumed = !primed || (acnt >= n);
  assign take     = swap && full && consumed;
  assign ld_ok    = load && (!full || take);
  assign weight_out = (k == '0) ? ret[ROWS-1] : act[0];

  always_comb begin
    for (int p = 0; p < ABUF; p++) begin
      pick[p] = '0;
      for (int q = 0; q < DEPTH; q++)
        if (p < int'(k) && q == int'(n) - 1 - p) pick[p] = pas[q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pas[i] <= '0;
      pcnt <= '0;
    end else begin
      if (ld_ok) begin
        pas[0] <= load_data;
        for (int i = 1; i < DEPTH; i++) pas[i] <= pas[i-1];
      end
      if (take) pcnt <= ld_ok ? CW'(1) : '0;
      else if (ld_ok) pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < ABUF; p++) act[p] <= '0;
      for (int r = 0; r < ROWS; r++) ret[r] <= '0;
      primed <= 1'b0;
      acnt   <= '0;
    end else if (take) begin
      for (int p = 0; p < ABUF; p++) act[p] <= pick[p];
      for (int r = 0; r < ROWS; r++) ret[r] <= pas[r];
      primed <= 1'b1;
      acnt   <= '0;
    end else if (advance) begin
      ret[0] <= weight_out;
      for (int r = 1; r < ROWS; r++) ret[r] <= ret[r-1];
      for (int p = 0; p < ABUF; p++) begin
        if (p == int'(k) - 1) act[p] <= ret[ROWS-1];
        else if (p < ABUF - 1) act[p] <= act[p+1];
      end
      if (primed && acnt < n) acnt <= acnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          swap,
  input logic          advance,
  input logic          full,
  input logic          primed,
  input logic [DW-1:0] weight_out
);
  assert_zero_unprimed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> weight_out == '0);

  assert_full_from_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(load));

  assert_full_clears_by_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(swap));

  assert_swap_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !full && !advance) |=> $stable(weight_out));

  assert_prime_by_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed) |-> $past(swap && full));
endmodule

bind pingpong_weight_buf pwb_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .swap(swap), .advance(advance),
  .full(full), .primed(primed), .weight_out(weight_out)
);

// File: tb/tb_pingpong_weight_buf.sv
module tb_pingpong_weight_buf;
  logic       clk = 0, rst_n = 0, load = 0, swap = 0, advance = 0;
  logic [2:0] w_sel = 3'd3;
  logic [7:0] load_data = 0, weight_out;
  logic       full;
  int checks = 0, errors = 0;
  int mp[25], mact[25];
  int mcnt, mlen, mpos, madv, nn;
  bit mprim, done = 0;

  pingpong_weight_buf dut (.clk(clk), .rst_n(rst_n), .w_sel(w_sel), .load(load),
    .load_data(load_data), .swap(swap), .advance(advance),
    .weight_out(weight_out), .full(full));

  always #2 clk = ~clk;

  function automatic int clampw(int w);
    if (w < 3) return 3;
    if (w > 5) return 5;
    return w;
  endfunction

  task automatic chk(string tag);
    int eo;
    bit ef;
    eo = mprim ? mact[mpos] : 0;
    ef = mcnt >= nn;
    checks += 2;
    if (int'(weight_out) != eo) begin
      errors++;
      $display("FAIL %s weight_out actual %0d expected %0d", tag, weight_out, eo);
    end
    if (full != ef) begin
      errors++;
      $display("FAIL %s full actual %0d expected %0d", tag, full, ef);
    end
  endtask

  task automatic step(bit l, int d, bit s, bit a, string tag);
    bit fm, tk;
    load = l; load_data = 8'(d); swap = s; advance = a;
    fm = mcnt >= nn;
    tk = s && fm && (!mprim || madv >= nn);
    if (tk) begin
      for (int j = 0; j < nn; j++) mact[j] = mp[j];
      mlen = nn; mpos = 0; madv = 0; mprim = 1;
      if (l) begin mp[0] = d & 255; mcnt = 1; end else mcnt = 0;
    end else begin
      if (l && !fm) begin mp[mcnt] = d & 255; mcnt++; end
      if (a && mprim) begin
        mpos = (mpos + 1) % mlen;
        if (madv < nn) madv++;
      end
    end
    @(negedge clk);
    chk(tag);
  endtask

  task automatic run_phase(int w, string tag);
    int c;
    w_sel = 3'(w);
    nn = clampw(w) * clampw(w);
    mcnt = 0; mpos = 0; madv = 0; mprim = 0; mlen = 1;
    load = 0; swap = 0; advance = 0;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 1, 0, "R4");
    for (int i = 0; i < nn; i++) step(1, 10 + i, 0, 0, "R3");
    step(1, 8'hEE, 0, 0, "R3");
    step(0, 0, 1, 0, "R5");
    for (int i = 0; i < nn; i++) step(1, 100 + i, 0, (i < nn - 1), "R10");
    step(0, 0, 1, 0, "R4");
    step(0, 0, 0, 1, "R6");
    step(1, 77, 1, 1, "R9");
    for (int i = 0; i < nn + 3; i++) step(0, 0, 0, 1, "R6");
    for (int i = 0; i < nn - 1; i++) step(1, 200 + i, 0, 1, "R10");
    step(0, 0, 1, 0, "R8");
    for (int i = 0; i < 400; i++) begin
      c = $urandom;
      step((c % 3) != 0, int'($urandom % 256), ((c >> 4) % 4) == 0,
           ((c >> 8) % 4) != 0, tag);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    @(negedge clk);
    run_phase(3, "R6");
    run_phase(4, "R6");
    run_phase(5, "R6");
    run_phase(7, "R2");
    run_phase(1, "R2");
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule